// File: doc/BRIEF.md
# Closed-Page Access and Refresh Sequencer

This block is the run-time command engine of a double-data-rate memory controller. It takes over once the power-up initialisation has finished, turns every host read or write into a self-contained closed-page access, and serves refresh requests. Each access opens a row with an activate command. After the row-to-column delay it issues a read or a write with the auto-precharge address bit set, so the row closes by itself after the burst. Every access therefore takes a fixed number of clocks, whatever address came before it.

The host holds `acc_req` together with the address and burst code until `acc_ack` pulses. It holds the direction select `acc_rd` until the read/write decision is taken, one clock before the column command. Refresh uses a level handshake. The requester holds `ref_req` until `ref_ack` rises. `ref_ack` stays high for the whole refresh, and a request still high when the refresh ends starts another one. The block drives the command bits, the bank and the address, plus two phase flags that tell a separate data path when read data arrives and when write data must be supplied. All timing values are parameters counted in clocks.

Top module: `ddr_access_seq`

## Requirements
- R1: In an idle cycle with `init_done` high, `acc_req` high and `ref_req` low, the next cycle carries an activate command. Here `mem_cmd` = {cs_n, ras_n, cas_n, we_n} = 4'b0011. `mem_ba` is the top BA_W bits of `acc_addr` and `mem_addr` is the row field, the middle ROW_W bits. `acc_ack` is high in that cycle only.
- R2: Exactly T_RCD cycles after the activate, a column command is issued: read 4'b0101 or write 4'b0100. `mem_ba` repeats the bank, the low COL_W bits of `mem_addr` carry the column field (the low bits of `acc_addr`), and bit AP_BIT of `mem_addr` is 1.
- R3: `acc_rd` is sampled only in the cycle just before the column command, T_RCD-1 cycles after the activate. A 1 selects a read and a 0 selects a write. Its value in any other cycle has no effect.
- R4: For a read, `rd_phase` is high for N consecutive cycles, starting CAS_LAT cycles after the read command. The block is idle in the cycle after the last one and accepts a waiting request there.
- R5: N comes from the 2-bit `burst_code` captured with the request: code 3 gives 4 clocks (8 beats), code 2 gives 2 clocks (4 beats), and codes 1 and 0 give 1 clock (2 beats).
- R6: For a write, `wr_phase` is high for the N cycles that follow the write command. Then T_DAL = T_WR + T_RP cycles of NOP follow, and after them the block is idle and accepts a waiting request.
- R7: In an idle cycle with `init_done` and `ref_req` high, the next cycle carries an auto-refresh command 4'b0001. `ref_ack` is high for T_RFC cycles starting with that cycle.
- R8: While `ref_ack` is high, `acc_ack` stays low and no activate, read or write is issued. A refresh request wins over an access request seen in the same idle cycle. A held access request is accepted in the cycle after `ref_ack` falls.
- R9: If `ref_req` is still high when a refresh ends, another refresh follows, with exactly one cycle of `ref_ack` low between the two.
- R10: While `init_done` is low, no request is accepted, and the outputs stay at NOP with zero bank and address.
- R11: Every cycle that carries no command drives NOP (4'b0111) with `mem_ba` and `mem_addr` zero.
- R12: During and right after reset, the outputs are NOP, zero bank and address, and all flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_done | input | 1 | Power-up initialisation complete |
| acc_req | input | 1 | Host access request, held until `acc_ack` |
| acc_rd | input | 1 | Direction: 1 read, 0 write |
| acc_addr | input | BA_W+ROW_W+COL_W | {bank, row, column} |
| burst_code | input | 2 | Burst length code |
| ref_req | input | 1 | Refresh request, level held |
| acc_ack | output | 1 | One-cycle access acceptance |
| ref_ack | output | 1 | High for the whole refresh |
| mem_cmd | output | 4 | {cs_n, ras_n, cas_n, we_n} |
| mem_ba | output | BA_W | Bank address |
| mem_addr | output | ROW_W | Row, or column with auto-precharge bit |
| rd_phase | output | 1 | Read data expected this cycle |
| wr_phase | output | 1 | Write data to be driven this cycle |

## Verification
The bench sweeps every burst code in both directions across all four banks. It flips `acc_rd` in every cycle except the sampling one, so a design that samples the direction at acceptance or too late issues the wrong column command. Accesses are issued back to back, so an off-by-one in the CAS-latency, data or tDAL counts shows up as a shifted phase flag or a late `acc_ack`. A simultaneous refresh and access exposes a wrong priority, and a held refresh request exposes a missing or extra gap between refreshes. Requests raised before `init_done` catch a design that starts too early.

// File: rtl/ddr_seq_pkg.sv
package ddr_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_ACT, S_RCD, S_RDC, S_WRC, S_CL,
    S_RDAT, S_WDAT, S_DAL, S_AREF, S_RFC
  } seq_state_t;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_ACT = 4'b0011;
  localparam logic [3:0] CMD_RD  = 4'b0101;
  localparam logic [3:0] CMD_WR  = 4'b0100;
  localparam logic [3:0] CMD_REF = 4'b0001;

  // clocks spent in a data state: two beats per clock
  function automatic logic [2:0] burst_clocks(input logic [1:0] code);
    case (code)
      2'd3:    burst_clocks = 3'd4;
      2'd2:    burst_clocks = 3'd2;
      default: burst_clocks = 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (load)      cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign last = (cnt == '0);
endmodule

// File: rtl/seq_out_reg.sv
module seq_out_reg
  import ddr_seq_pkg::*;
#(
  parameter int BA_W   = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int AP_BIT = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  seq_state_t       st_q,
  input  seq_state_t       st_d,
  input  logic [BA_W-1:0]  live_ba,
  input  logic [ROW_W-1:0] live_row,
  input  logic [BA_W-1:0]  held_ba,
  input  logic [COL_W-1:0] held_col,
  output logic [3:0]       cmd,
  output logic [BA_W-1:0]  ba,
  output logic [ROW_W-1:0] addr,
  output logic             rd_phase,
  output logic             wr_phase,
  output logic             ref_ack,
  output logic             acc_ack
);
  logic [ROW_W-1:0] col_ap;

  always_comb begin
    col_ap              = '0;
    col_ap[COL_W-1:0]   = held_col;
    col_ap[AP_BIT]      = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd      <= CMD_NOP;
      ba       <= '0;
      addr     <= '0;
      rd_phase <= 1'b0;
      wr_phase <= 1'b0;
      ref_ack  <= 1'b0;
      acc_ack  <= 1'b0;
    end else begin
      cmd  <= CMD_NOP;
      ba   <= '0;
      addr <= '0;
      case (st_d)
        S_ACT:  begin cmd <= CMD_ACT; ba <= live_ba; addr <= live_row; end
        S_RDC:  begin cmd <= CMD_RD;  ba <= held_ba; addr <= col_ap;   end
        S_WRC:  begin cmd <= CMD_WR;  ba <= held_ba; addr <= col_ap;   end
        S_AREF: cmd <= CMD_REF;
        default: ;
      endcase
      rd_phase <= (st_d == S_RDAT);
      wr_phase <= (st_d == S_WDAT);
      ref_ack  <= (st_d == S_AREF) || (st_d == S_RFC);
      acc_ack  <= (st_q == S_IDLE) && (st_d == S_ACT);
    end
  end
endmodule

// File: rtl/ddr_access_seq.sv
module ddr_access_seq
  import ddr_seq_pkg::*;
#(
  parameter int BA_W    = 2,
  parameter int ROW_W   = 13,
  parameter int COL_W   = 10,
  parameter int AP_BIT  = 10,
  parameter int T_RCD   = 3,
  parameter int CAS_LAT = 2,
  parameter int T_WR    = 2,
  parameter int T_RP    = 3,
  parameter int T_RFC   = 6,
  parameter int CNT_W   = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        init_done,
  input  logic                        acc_req,
  input  logic                        acc_rd,
  input  logic [BA_W+ROW_W+COL_W-1:0] acc_addr,
  input  logic [1:0]                  burst_code,
  input  logic                        ref_req,
  output logic                        acc_ack,
  output logic                        ref_ack,
  output logic [3:0]                  mem_cmd,
  output logic [BA_W-1:0]             mem_ba,
  output logic [ROW_W-1:0]            mem_addr,
  output logic                        rd_phase,
  output logic                        wr_phase
);
  localparam int T_DAL = T_WR + T_RP;
  localparam int AW    = BA_W + ROW_W + COL_W;

  seq_state_t       st_q, st_d;
  logic             tmr_last, tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic [BA_W-1:0]  held_ba;
  logic [COL_W-1:0] held_col;
  logic [1:0]       held_code;

  wire [BA_W-1:0]  live_ba  = acc_addr[AW-1 -: BA_W];
  wire [ROW_W-1:0] live_row = acc_addr[COL_W +: ROW_W];

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE: if (init_done && ref_req)      st_d = S_AREF;
              else if (init_done && acc_req) st_d = S_ACT;
      S_ACT:  st_d = S_RCD;
      S_RCD:  if (tmr_last) st_d = acc_rd ? S_RDC : S_WRC;
      S_RDC:  st_d = S_CL;
      S_CL:   if (tmr_last) st_d = S_RDAT;
      S_RDAT: if (tmr_last) st_d = S_IDLE;
      S_WRC:  st_d = S_WDAT;
      S_WDAT: if (tmr_last) st_d = S_DAL;
      S_DAL:  if (tmr_last) st_d = S_IDLE;
      S_AREF: st_d = S_RFC;
      S_RFC:  if (tmr_last) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_comb begin
    tmr_val = '0;
    case (st_d)
      S_RCD:          tmr_val = CNT_W'(T_RCD - 2);
      S_CL:           tmr_val = CNT_W'(CAS_LAT - 2);
      S_RDAT, S_WDAT: tmr_val = CNT_W'(burst_clocks(held_code) - 3'd1);
      S_DAL:          tmr_val = CNT_W'(T_DAL - 1);
      S_RFC:          tmr_val = CNT_W'(T_RFC - 2);
      default:        tmr_val = '0;
    endcase
  end
  assign tmr_load = (st_d != st_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= S_IDLE;
      held_ba   <= '0;
      held_col  <= '0;
      held_code <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == S_IDLE && st_d == S_ACT) begin
        held_ba   <= live_ba;
        held_col  <= acc_addr[COL_W-1:0];
        held_code <= burst_code;
      end
    end
  end

  seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .last(tmr_last)
  );

  seq_out_reg #(.BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W), .AP_BIT(AP_BIT)) u_out (
    .clk(clk), .rst(rst), .st_q(st_q), .st_d(st_d),
    .live_ba(live_ba), .live_row(live_row), .held_ba(held_ba), .held_col(held_col),
    .cmd(mem_cmd), .ba(mem_ba), .addr(mem_addr),
    .rd_phase(rd_phase), .wr_phase(wr_phase), .ref_ack(ref_ack), .acc_ack(acc_ack)
  );

  AST_COL_AUTO_PRECHARGE: assert property (@(posedge clk) disable iff (rst)
    (mem_cmd == CMD_RD || mem_cmd == CMD_WR) |-> mem_addr[AP_BIT]); // R2
  AST_ACK_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    acc_ack |=> !acc_ack); // R1
  AST_REFRESH_BLOCKS_ACCESS: assert property (@(posedge clk) disable iff (rst)
    ref_ack |-> (!acc_ack && mem_cmd != CMD_ACT && mem_cmd != CMD_RD && mem_cmd != CMD_WR)); // R8
  AST_WAIT_FOR_INIT: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_IDLE && !init_done) |=> (mem_cmd == CMD_NOP && !ref_ack)); // R10
  AST_REFRESH_STARTS_WITH_CMD: assert property (@(posedge clk) disable iff (rst)
    $rose(ref_ack) |-> (mem_cmd == CMD_REF)); // R7
  AST_PHASES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_phase, wr_phase, ref_ack})); // R4
endmodule

// File: tb/ddr_access_seq_tb_top.sv
`timescale 1ns/1ps
module ddr_access_seq_tb_top;
  localparam int BA_W = 2, ROW_W = 13, COL_W = 10, AP_BIT = 10;
  localparam int T_RCD = 3, CAS_LAT = 2, T_WR = 2, T_RP = 3, T_RFC = 6;
  localparam int T_DAL = T_WR + T_RP;
  localparam int AW = BA_W + ROW_W + COL_W;
  localparam int VW = 8 + BA_W + ROW_W;
  localparam logic [3:0] NOP = 4'b0111, ACT = 4'b0011, RDC = 4'b0101,
                         WRC = 4'b0100, REF = 4'b0001;

  logic clk = 1'b0, rst = 1'b1, init_done = 1'b0;
  logic acc_req = 1'b0, acc_rd = 1'b0, ref_req = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [1:0] burst_code = '0;
  logic acc_ack, ref_ack, rd_phase, wr_phase;
  logic [3:0] mem_cmd;
  logic [BA_W-1:0] mem_ba;
  logic [ROW_W-1:0] mem_addr;
  int n_checks = 0, n_fails = 0;

  always #2 clk = ~clk;

  ddr_access_seq #(.BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W), .AP_BIT(AP_BIT),
    .T_RCD(T_RCD), .CAS_LAT(CAS_LAT), .T_WR(T_WR), .T_RP(T_RP), .T_RFC(T_RFC)) dut_i (
    .clk(clk), .rst(rst), .init_done(init_done), .acc_req(acc_req), .acc_rd(acc_rd),
    .acc_addr(acc_addr), .burst_code(burst_code), .ref_req(ref_req),
    .acc_ack(acc_ack), .ref_ack(ref_ack), .mem_cmd(mem_cmd), .mem_ba(mem_ba),
    .mem_addr(mem_addr), .rd_phase(rd_phase), .wr_phase(wr_phase));

  function automatic logic [VW-1:0] mk(input logic [3:0] c, input logic rp, input logic wp,
      input logic ra, input logic aa, input logic [BA_W-1:0] b, input logic [ROW_W-1:0] a);
    return {c, rp, wp, ra, aa, b, a};
  endfunction

  wire [VW-1:0] obs = {mem_cmd, rd_phase, wr_phase, ref_ack, acc_ack, mem_ba, mem_addr};

  task automatic check(input logic [VW-1:0] exp, input string tag);
    n_checks++;
    if (obs !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, obs, exp);
    end
  endtask

  task automatic check_bit(input logic act, input logic exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // starts and ends at a negedge; ends in the idle cycle after the access
  task automatic do_access(input logic rd, input logic [BA_W-1:0] b, input logic [ROW_W-1:0] row,
      input logic [COL_W-1:0] col, input logic [1:0] code, input logic expect_now);
    int n, e, wcnt;
    logic [ROW_W-1:0] cap;
    n = (code == 2'd3) ? 4 : (code == 2'd2) ? 2 : 1;       // R5
    e = rd ? (T_RCD + CAS_LAT + n - 1) : (T_RCD + n + T_DAL);
    cap = '0; cap[COL_W-1:0] = col; cap[AP_BIT] = 1'b1;
    acc_req = 1'b1; acc_addr = {b, row, col}; burst_code = code; acc_rd = ~rd;
    wcnt = 0;
    do begin @(negedge clk); wcnt++; end while (!acc_ack && wcnt < 50);
    if (expect_now) check_bit(wcnt == 1, 1'b1, "R4 R6 idle accepts at once");
    for (int k = 0; k <= e + 1; k++) begin
      logic [3:0] c; logic [BA_W-1:0] eb; logic [ROW_W-1:0] ea; logic rp, wp;
      c = NOP; eb = '0; ea = '0;
      if (k == 0) begin c = ACT; eb = b; ea = row; end
      else if (k == T_RCD) begin c = rd ? RDC : WRC; eb = b; ea = cap; end
      rp = rd && k >= T_RCD + CAS_LAT && k < T_RCD + CAS_LAT + n;
      wp = !rd && k > T_RCD && k <= T_RCD + n;
      if (k == 0) check(mk(c, rp, wp, 1'b0, 1'b1, eb, ea), "R1 activate");
      else if (k == T_RCD) check(mk(c, rp, wp, 1'b0, 1'b0, eb, ea), "R2 R3 column command");
      else if (rd) check(mk(c, rp, wp, 1'b0, 1'b0, eb, ea), "R4 R5 R11 read timeline");
      else check(mk(c, rp, wp, 1'b0, 1'b0, eb, ea), "R6 R5 R11 write timeline");
      if (k == 0) acc_req = 1'b0;
      acc_rd = (k == T_RCD - 2 || k == T_RCD - 1) ? rd : ~rd;
      if (k < e + 1) @(negedge clk);
    end
  endtask

  task automatic do_refresh(input int reps);
    ref_req = 1'b1;
    @(negedge clk);
    for (int r = 0; r < reps; r++) begin
      for (int k = 0; k <= T_RFC; k++) begin
        if (r > 0) check(mk((k == 0) ? REF : NOP, 1'b0, 1'b0, k < T_RFC, 1'b0, '0, '0), "R9 repeated refresh");
        else check(mk((k == 0) ? REF : NOP, 1'b0, 1'b0, k < T_RFC, 1'b0, '0, '0), "R7 refresh");
        if (k == 0 && r == reps - 1) ref_req = 1'b0;
        if (!(r == reps - 1 && k == T_RFC)) @(negedge clk);
      end
    end
  endtask

  initial begin
    #400000;
    n_fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(mk(NOP, 0, 0, 0, 0, '0, '0), "R12 reset state");
    rst = 1'b0;
    // R10: requests before init_done
    acc_req = 1'b1; ref_req = 1'b1; acc_addr = '1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check(mk(NOP, 0, 0, 0, 0, '0, '0), "R10 no start before init");
    end
    acc_req = 1'b0; ref_req = 1'b0;
    @(negedge clk);
    check(mk(NOP, 0, 0, 0, 0, '0, '0), "R12 idle after reset");
    init_done = 1'b1;
    @(negedge clk);
    // sweep: burst codes, directions, banks, back to back
    for (int code = 0; code < 4; code++)
      for (int d = 0; d < 2; d++)
        for (int b = 0; b < 4; b++)
          do_access(d[0], b[BA_W-1:0], ROW_W'(13'h0A5 * (b + 1) + code),
                    COL_W'(10'h3C1 ^ (b * 37 + d)), code[1:0], 1'b1);
    // refresh once, then held for two
    do_refresh(1);
    do_refresh(2);
    // R8: simultaneous refresh and access
    ref_req = 1'b1; acc_req = 1'b1; acc_rd = 1'b1; burst_code = 2'd2;
    acc_addr = {2'd3, 13'h1234, 10'h155};
    @(negedge clk);
    for (int k = 0; k <= T_RFC; k++) begin
      check(mk((k == 0) ? REF : NOP, 1'b0, 1'b0, k < T_RFC, 1'b0, '0, '0), "R8 refresh wins");
      if (k == 0) ref_req = 1'b0;
      @(negedge clk);
    end
    check(mk(ACT, 0, 0, 0, 1, 2'd3, 13'h1234), "R8 held access after refresh");
    acc_req = 1'b0;
    repeat (30) @(negedge clk);
    do_access(1'b0, 2'd1, 13'h1FFF, 10'h3FF, 2'd3, 1'b1);
    do_access(1'b1, 2'd2, 13'h0000, 10'h000, 2'd1, 1'b1);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule